// File: doc/BRIEF.md
# Two-Stage Pipelined SHA-1 Compression Core

This block runs the SHA-1 compression function and performs one round in each clock cycle. The eighty rounds are split across two stages of forty rounds each. A block can enter the first stage while the block ahead of it runs its last forty rounds in the second stage. As a result, two independent compressions are in flight together and a new block can start every forty cycles.

Each request carries three things: a 160-bit chaining value, a 512-bit message block and a context tag. The core returns the updated chaining value with the same tag, in the order the requests were issued.

Two input flags help with short messages. One flag replaces the chaining input with the standard initial value. The other flag builds the final block of a 672-bit message: it keeps the block's leading 160 data bits and fills the remaining bits with a constant pattern, so no padding is computed at run time. A message's second block depends on the first block's result, so the core will not accept a block whose tag matches a block still in flight.

Top module: `sha1_pipe2_core`

## Requirements
- R1: After reset, ready_o is 1 and valid_o is 0.
- R2: For each accepted request, digest_o equals the SHA-1 compression of the block under the chaining value. Each output word is the input chaining word plus the matching working word after round 79, modulo 2^32. Bit positions:
  - block_i[511:480] is schedule word 0.
  - chain_i[159:128] is chaining word 0, and digest_o uses the same order.
  - Round constants are 5A827999, 6ED9EBA1, 8F1BBCDC and CA62C1D6, each for 20 rounds in that order.
  - The round functions are choice, parity, majority and parity, in that order.
- R3: A block runs rounds 0 to 39 in the first stage, then rounds 40 to 79 in the second. ready_o is 0 while the first stage is before its last round. A new request can be accepted in the same cycle the first stage finishes round 39, so back-to-back requests are accepted 40 cycles apart.
- R4: valid_o rises 80 clock edges after the edge that accepts a request, and tag_o then equals that request's tag.
- R5: Results leave in issue order, and each valid_o pulse lasts exactly one cycle.
- R6: When use_iv_i is 1, chain_i is ignored and the chaining value is 67452301 EFCDAB89 98BADCFE 10325476 C3D2E1F0.
- R7: When pad_i is 1, the core keeps block_i[511:352] and replaces the lower 352 bits with a fixed pattern: one 1 bit, then 287 zero bits, then a 64-bit length of 672.
- R8: ready_o is 0 when tag_i equals one of these tags:
  - the tag of the block in the first stage;
  - the tag of the block in the second stage, unless that block is in its final round.
- R9: The core returns the standard digests for two single-block messages:
  - the empty message: da39a3ee5e6b4b0d3255bfef95601890afd80709;
  - "abc": a9993e364706816aba3e25717850c26c9cd0d89d.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Request present |
| ready_o | output | 1 | Request accepted this cycle when valid_i is high |
| use_iv_i | input | 1 | Use the standard initial value instead of chain_i |
| pad_i | input | 1 | Apply the fixed 672-bit final-block pattern |
| chain_i | input | 160 | Incoming chaining value |
| block_i | input | 512 | Message block |
| tag_i | input | TAG_W | Context tag of the request |
| valid_o | output | 1 | One-cycle result strobe |
| digest_o | output | 160 | Updated chaining value |
| tag_o | output | TAG_W | Tag of the result |

## Verification
The bench builds the core with its defaults: a 4-bit tag and a 672-bit fixed message length. This tag width leaves enough values for the hazard test, which keeps one tag in the second stage while a different tag enters the first. The fixed length makes the padded tail exactly 352 bits, so a complete two-block 672-bit message can be hashed and compared with an independent reference model. Random blocks and chaining values exercise the four round groups. The two published single-block vectors check the constants and the initial value.

// File: rtl/sha1_pipe2_pkg.sv
package sha1_pipe2_pkg;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned WIN_LEN = 16;

  localparam logic [159:0] SHA1_IV =
    160'h67452301_EFCDAB89_98BADCFE_10325476_C3D2E1F0;

  typedef struct packed {
    logic [159:0]                     chain;
    logic [159:0]                     work;  // a,b,c,d,e from msb
    logic [WIN_LEN-1:0][WORD_W-1:0]   win;   // win[0] = W[t]
  } ctx_t;

  function automatic logic [31:0] rotl(input logic [31:0] x, input int unsigned n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [31:0] round_k(input logic [6:0] t);
    if (t < 7'd20)      return 32'h5A827999;
    else if (t < 7'd40) return 32'h6ED9EBA1;
    else if (t < 7'd60) return 32'h8F1BBCDC;
    else                return 32'hCA62C1D6;
  endfunction

  function automatic logic [31:0] round_f(input logic [6:0] t, input logic [31:0] b,
                                          input logic [31:0] c, input logic [31:0] d);
    if (t < 7'd20)      return (b & c) | (~b & d);
    else if (t < 7'd40) return b ^ c ^ d;
    else if (t < 7'd60) return (b & c) | (b & d) | (c & d);
    else                return b ^ c ^ d;
  endfunction

endpackage

// File: rtl/sha1_fixed_pad.sv
module sha1_fixed_pad #(
  parameter int unsigned MSG_BITS = 672
) (
  input  logic         pad_en_i,
  input  logic [511:0] block_i,
  output logic [511:0] block_o
);
  localparam int unsigned DATA_BITS = MSG_BITS % 512;
  localparam logic [511:0] KEEP = ~((512'd1 << (512 - DATA_BITS)) - 512'd1);
  localparam logic [511:0] TAIL = (512'd1 << (511 - DATA_BITS)) | 512'(MSG_BITS);

  assign block_o = pad_en_i ? ((block_i & KEEP) | TAIL) : block_i;
endmodule

// File: rtl/sha1_round_stage.sv
module sha1_round_stage
  import sha1_pipe2_pkg::*;
#(
  parameter int unsigned FIRST  = 0,
  parameter int unsigned ROUNDS = 40,
  parameter int unsigned TAG_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  ctx_t             ctx_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             busy_o,
  output logic             last_o,
  output ctx_t             ctx_o,
  output logic [TAG_W-1:0] tag_o
);
  localparam int unsigned CNT_W = $clog2(ROUNDS);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  ctx_t             ctx_q;
  logic [TAG_W-1:0] tag_q;
  logic [6:0]       t;
  logic [31:0]      a, b, c, d, e, a_n;

  assign t = 7'(FIRST) + 7'(cnt_q);
  assign {a, b, c, d, e} = ctx_q.work;
  assign a_n = rotl(a, 5) + round_f(t, b, c, d) + e + ctx_q.win[0] + round_k(t);

  always_comb begin
    ctx_o.chain = ctx_q.chain;
    ctx_o.work  = {a_n, a, rotl(b, 30), c, d};
    for (int i = 0; i < WIN_LEN - 1; i++) ctx_o.win[i] = ctx_q.win[i+1];
    ctx_o.win[WIN_LEN-1] = rotl(ctx_q.win[13] ^ ctx_q.win[8] ^ ctx_q.win[2] ^ ctx_q.win[0], 1);
  end

  assign busy_o = busy_q;
  assign last_o = busy_q && (cnt_q == CNT_W'(ROUNDS - 1));
  assign tag_o  = tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      ctx_q  <= '0;
      tag_q  <= '0;
    end else if (load_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      ctx_q  <= ctx_i;
      tag_q  <= tag_i;
    end else if (busy_q) begin
      ctx_q  <= ctx_o;
      cnt_q  <= cnt_q + 1'b1;
      if (last_o) busy_q <= 1'b0;
    end
  end

  p_load_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> busy_q && cnt_q == '0);
  p_run_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !last_o) |=> busy_q);
endmodule

// File: rtl/sha1_pipe2_core.sv
module sha1_pipe2_core
  import sha1_pipe2_pkg::*;
#(
  parameter int unsigned TAG_W    = 4,
  parameter int unsigned MSG_BITS = 672
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  output logic             ready_o,
  input  logic             use_iv_i,
  input  logic             pad_i,
  input  logic [159:0]     chain_i,
  input  logic [511:0]     block_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             valid_o,
  output logic [159:0]     digest_o,
  output logic [TAG_W-1:0] tag_o
);
  localparam int unsigned STAGE_ROUNDS = 40;

  logic [511:0]     blk;
  ctx_t             in_ctx, s1_ctx, s2_ctx;
  logic             s1_busy, s1_last, s2_busy, s2_last, accept;
  logic [TAG_W-1:0] s1_tag, s2_tag;
  logic [159:0]     sum;

  sha1_fixed_pad #(.MSG_BITS(MSG_BITS)) u_pad (
    .pad_en_i(pad_i), .block_i(block_i), .block_o(blk)
  );

  always_comb begin
    in_ctx.chain = use_iv_i ? SHA1_IV : chain_i;
    in_ctx.work  = in_ctx.chain;
    for (int i = 0; i < WIN_LEN; i++) in_ctx.win[i] = blk[511-32*i -: 32];
  end

  // same-tag blocks must not overlap: block 2 needs block 1's result
  assign ready_o = (!s1_busy || s1_last)
                && !(s1_busy && s1_tag == tag_i)
                && !(s2_busy && !s2_last && s2_tag == tag_i);
  assign accept  = valid_i && ready_o;

  sha1_round_stage #(.FIRST(0), .ROUNDS(STAGE_ROUNDS), .TAG_W(TAG_W)) u_stage1 (
    .clk_i, .rst_ni, .load_i(accept), .ctx_i(in_ctx), .tag_i(tag_i),
    .busy_o(s1_busy), .last_o(s1_last), .ctx_o(s1_ctx), .tag_o(s1_tag)
  );

  sha1_round_stage #(.FIRST(STAGE_ROUNDS), .ROUNDS(STAGE_ROUNDS), .TAG_W(TAG_W)) u_stage2 (
    .clk_i, .rst_ni, .load_i(s1_last), .ctx_i(s1_ctx), .tag_i(s1_tag),
    .busy_o(s2_busy), .last_o(s2_last), .ctx_o(s2_ctx), .tag_o(s2_tag)
  );

  always_comb
    for (int i = 0; i < 5; i++)
      sum[159-32*i -: 32] = s2_ctx.chain[159-32*i -: 32] + s2_ctx.work[159-32*i -: 32];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      digest_o <= '0;
      tag_o    <= '0;
    end else begin
      valid_o <= s2_last;
      if (s2_last) begin
        digest_o <= sum;
        tag_o    <= s2_tag;
      end
    end
  end

  p_handoff_free_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_last |-> (!s2_busy || s2_last));
  p_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  p_out_tag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s2_last |=> (valid_o && tag_o == $past(s2_tag)));
  p_no_clash_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && s1_busy) |-> (s1_tag != tag_i));
endmodule

// File: tb/sha1_pipe2_core_bench.sv
`timescale 1ns/1ps
module sha1_pipe2_core_bench;
  localparam int TAG_W = 4;
  localparam logic [159:0] IV = 160'h67452301EFCDAB8998BADCFE10325476C3D2E1F0;

  logic clk = 0, rst_n = 0;
  logic valid_i = 0, use_iv_i = 0, pad_i = 0;
  logic [159:0] chain_i = '0;
  logic [511:0] block_i = '0;
  logic [TAG_W-1:0] tag_i = '0;
  logic ready_o, valid_o;
  logic [159:0] digest_o;
  logic [TAG_W-1:0] tag_o;

  always #10 clk = ~clk;

  sha1_pipe2_core #(.TAG_W(TAG_W), .MSG_BITS(672)) u_sha1_pipe2_core (
    .clk_i(clk), .rst_ni(rst_n), .valid_i, .ready_o, .use_iv_i, .pad_i,
    .chain_i, .block_i, .tag_i, .valid_o, .digest_o, .tag_o
  );

  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [159:0] act, input logic [159:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [159:0] ref_cmp(input logic [159:0] h, input logic [511:0] m);
    logic [31:0] w[80];
    logic [31:0] a, b, c, d, e, f, k, tmp;
    for (int t = 0; t < 16; t++) w[t] = m[511-32*t -: 32];
    for (int t = 16; t < 80; t++) w[t] = rl(w[t-3] ^ w[t-8] ^ w[t-14] ^ w[t-16], 1);
    {a, b, c, d, e} = h;
    for (int t = 0; t < 80; t++) begin
      if (t < 20)      begin f = (b & c) | (~b & d);          k = 32'h5A827999; end
      else if (t < 40) begin f = b ^ c ^ d;                   k = 32'h6ED9EBA1; end
      else if (t < 60) begin f = (b & c) | (b & d) | (c & d); k = 32'h8F1BBCDC; end
      else             begin f = b ^ c ^ d;                   k = 32'hCA62C1D6; end
      tmp = rl(a, 5) + f + e + w[t] + k;
      e = d; d = c; c = rl(b, 30); b = a; a = tmp;
    end
    return {h[159:128] + a, h[127:96] + b, h[95:64] + c, h[63:32] + d, h[31:0] + e};
  endfunction

  function automatic logic [511:0] pad672(input logic [511:0] bl);
    return {bl[511:352], 1'b1, 287'b0, 64'd672};
  endfunction

  logic [159:0]     exp_dig[64];
  logic [TAG_W-1:0] exp_tag[64];
  int               exp_cyc[64];
  int wr = 0, rd = 0;
  logic [159:0] last_dig;
  bit prev_v = 0;

  task automatic push_exp(input logic [159:0] ch, input logic [511:0] bl, input logic [TAG_W-1:0] tg,
                          input bit iv, input bit pd, input int acc);
    exp_dig[wr] = ref_cmp(iv ? IV : ch, pd ? pad672(bl) : bl);
    exp_tag[wr] = tg;
    exp_cyc[wr] = acc + 81;
    wr++;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (valid_o && prev_v) check(0, "R5 pulse longer than one cycle", 160'd1, 160'd0);
      if (valid_o) begin
        if (rd < wr) begin
          check(digest_o == exp_dig[rd], "R2 digest", digest_o, exp_dig[rd]);
          check(tag_o == exp_tag[rd], "R4/R5 tag order", 160'(tag_o), 160'(exp_tag[rd]));
          check(cyc == exp_cyc[rd], "R4 latency", 160'(cyc), 160'(exp_cyc[rd]));
          last_dig = digest_o;
          rd++;
        end else check(0, "R5 unexpected result", 160'(tag_o), 160'd0);
      end
      prev_v = valid_o;
    end
  end

  task automatic issue(input logic [159:0] ch, input logic [511:0] bl, input logic [TAG_W-1:0] tg,
                       input bit iv, input bit pd, output int acc);
    @(negedge clk);
    chain_i = ch; block_i = bl; tag_i = tg; use_iv_i = iv; pad_i = pd; valid_i = 1;
    #1;
    while (!ready_o) begin @(negedge clk); #1; end
    acc = cyc;
    push_exp(ch, bl, tg, iv, pd, acc);
    @(posedge clk); #1 valid_i = 0;
  endtask

  task automatic wait_cyc(input int c);
    do @(negedge clk); while (cyc < c);
  endtask

  task automatic drain();
    while (rd < wr) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [159:0] rnd160();
    return {$urandom, $urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 50000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int a0, a1, a2;
    logic [511:0] b1, b2;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(ready_o == 1'b1, "R1 ready after reset", 160'(ready_o), 160'd1);
    check(valid_o == 1'b0, "R1 valid after reset", 160'(valid_o), 160'd0);

    // R9 published vectors, R6 initial value with garbage on chain_i
    issue(rnd160(), {32'h80000000, 480'b0}, 4'd1, 1, 0, a0);
    drain();
    check(last_dig == 160'hda39a3ee5e6b4b0d3255bfef95601890afd80709, "R9 empty", last_dig,
          160'hda39a3ee5e6b4b0d3255bfef95601890afd80709);
    issue(rnd160(), {32'h61626380, 416'b0, 64'h18}, 4'd2, 1, 0, a0);
    drain();
    check(last_dig == 160'ha9993e364706816aba3e25717850c26c9cd0d89d, "R9 abc", last_dig,
          160'ha9993e364706816aba3e25717850c26c9cd0d89d);

    // R3 back-to-back overlap, R2 random chain and block
    issue(rnd160(), rnd512(), 4'd4, 0, 0, a0);
    issue(rnd160(), rnd512(), 4'd6, 0, 0, a1);
    check(a1 == a0 + 40, "R3 second accept cycle", 160'(a1), 160'(a0 + 40));
    issue(rnd160(), rnd512(), 4'd7, 0, 1, a2);
    check(a2 == a1 + 40, "R3 third accept cycle", 160'(a2), 160'(a1 + 40));
    drain();

    // R8 tag hazard and R3 mid-stage stall
    issue(rnd160(), rnd512(), 4'd3, 0, 0, a0);
    wait_cyc(a0 + 20);
    tag_i = 4'd9; valid_i = 1; #1;
    check(ready_o == 1'b0, "R3 stalled mid stage", 160'(ready_o), 160'd0);
    valid_i = 0;
    wait_cyc(a0 + 40);
    tag_i = 4'd3; valid_i = 1; #1;
    check(ready_o == 1'b0, "R8 same tag in stage 1", 160'(ready_o), 160'd0);
    b1 = rnd512(); chain_i = rnd160(); block_i = b1; tag_i = 4'd5; use_iv_i = 0; pad_i = 0; #1;
    check(ready_o == 1'b1, "R3 accept at stage 1 last round", 160'(ready_o), 160'd1);
    push_exp(chain_i, b1, 4'd5, 0, 0, cyc);
    @(posedge clk); #1 valid_i = 0;
    wait_cyc(a0 + 80);
    tag_i = 4'd5; valid_i = 1; #1;
    check(ready_o == 1'b0, "R8 same tag in stage 1 again", 160'(ready_o), 160'd0);
    b2 = rnd512(); chain_i = rnd160(); block_i = b2; tag_i = 4'd3; #1;
    check(ready_o == 1'b1, "R8 tag free when stage 2 finishing", 160'(ready_o), 160'd1);
    push_exp(chain_i, b2, 4'd3, 0, 0, cyc);
    @(posedge clk); #1 valid_i = 0;
    drain();

    // R7 full 672-bit message in two dependent blocks
    b1 = rnd512(); b2 = rnd512();
    issue(rnd160(), b1, 4'd8, 1, 0, a0);
    drain();
    issue(last_dig, b2, 4'd8, 0, 1, a1);
    drain();
    check(last_dig == ref_cmp(ref_cmp(IV, b1), {b2[511:352], 1'b1, 287'b0, 64'd672}),
          "R7 672-bit message", last_dig,
          ref_cmp(ref_cmp(IV, b1), {b2[511:352], 1'b1, 287'b0, 64'd672}));

    // R2 R6 R7 random mix
    for (int i = 0; i < 8; i++) begin
      bit iv, pd;
      iv = 1'($urandom); pd = 1'($urandom);
      issue(rnd160(), rnd512(), 4'($urandom), iv, pd, a0);
    end
    drain();
    check(rd == wr, "R5 all results returned", 160'(rd), 160'(wr));

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule